// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides which clocks, oscillator parts and the processor core run in each power mode. Software writes a 3-bit mode code. In active mode everything runs. Five sleep levels shut down more of the clock tree at each step, and the deepest level also stops the crystal oscillator. Six registered enables leave the block, together with the current mode code.

An interrupt request in any sleep level wakes the device to active mode so that the handler can run. While the handler runs, the sleep level that was interrupted is kept in a saved-mode register. An interrupt-return strobe restores that level. The handler can clear the saved level, and the device then stays active after the return.

Straight after reset the block checks the reset-vector word. If that word is all ones (an unprogrammed memory), the block drops into the deepest sleep level at once.

The controller is a four-state machine:
- `ST_BOOT` is the single cycle after reset. It holds the vector decision.
- `ST_ACTIVE` is normal running.
- `ST_SLEEP` covers every sleep level.
- `ST_SERVICE` is the interrupt handler.

The transitions are:
- boot-to-active: the vector word is programmed.
- boot-to-sleep: the vector word is blank.
- active-to-sleep: software writes a sleep code.
- active-to-service: an interrupt arrives while active.
- sleep-to-service: an interrupt arrives while asleep. This is the wake.
- service-to-active: return with a saved code of 0.
- service-to-sleep: return with a saved sleep code.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: While reset is asserted, `cur_mode` is 0 (active), all six enables are 1 and `wake` is 0.
- R2: At the first clock edge after reset release, the block samples `rst_vec`. If every bit is 1, `cur_mode` becomes 5 (deepest sleep). Otherwise it stays 0. `rst_vec` is ignored at every later edge.
- R3: Mode codes: 0 is active, and 1 to 5 are sleep levels 0 to 4. In active mode, a `mode_wr` pulse with `mode_sel` set to 1..5 moves `cur_mode` to that code at the next edge. Codes 0, 6 and 7 leave the block in active mode.
- R4: The enables are ordered {cpu, mclk, smclk, aclk, dcgen, xosc}. Code 0 gives all ones. Code 1 gives cpu=0, mclk=0 and all others 1.
- R5: Code 2 gives the same enables as code 1, except that dcgen equals `osc_used` as sampled at the previous edge.
- R6: Code 3 gives cpu, mclk and smclk at 0, with aclk, dcgen and xosc at 1. Code 4 is the same with dcgen at 0.
- R7: Code 5 gives all six enables at 0.
- R8: An `irq_req` sampled while in a sleep level sets `cur_mode` to 0 and all enables to 1 at the next edge. `wake` is high for exactly that one cycle.
- R9: An `irq_ret` pulse during service restores the code that was current when the interrupt was taken. An interrupt taken while active returns to active.
- R10: A `save_clr` pulse during service, whether earlier than `irq_ret` or in the same cycle, makes the return go to active mode.
- R11: `mode_wr` is ignored while asleep or in service. `irq_req` is ignored in service. `irq_ret` and `save_clr` are ignored outside service.
- R12: In active mode, `irq_req` takes priority over a `mode_wr` in the same cycle. The block enters service, and a later return goes back to active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rst_vec | input | 16 | Reset-vector word, checked once after reset |
| mode_wr | input | 1 | Software write strobe for the mode code |
| mode_sel | input | 3 | Mode code written by software |
| irq_req | input | 1 | Interrupt request |
| irq_ret | input | 1 | Interrupt-return strobe |
| save_clr | input | 1 | Clears the saved mode during service |
| osc_used | input | 1 | Oscillator dc generator is in use in active mode |
| cpu_en | output | 1 | Processor core enable |
| mclk_en | output | 1 | Main clock enable |
| smclk_en | output | 1 | Subsystem clock enable |
| aclk_en | output | 1 | Auxiliary clock enable |
| dcgen_en | output | 1 | Oscillator dc generator enable |
| xosc_en | output | 1 | Crystal oscillator enable |
| cur_mode | output | 3 | Current mode code |
| wake | output | 1 | One-cycle wake indication |

## Verification
Every output comes from a register loaded at the edge that samples the stimulus:
- a mode write, an interrupt, a return or the vector decision shows on `cur_mode`, on the enables and on `wake` one edge later;
- a change of `osc_used` while in code 2 reaches `dcgen_en` one edge later.

The bench drives inputs on the falling edge. A behavioural model is updated on each rising edge from the same inputs. Every output is compared with the model on the following falling edge, so each result is checked in the first cycle it is due and in every cycle after it.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] M_ACT  = 3'd0;
    localparam logic [MODE_W-1:0] M_LPM0 = 3'd1;
    localparam logic [MODE_W-1:0] M_LPM1 = 3'd2;
    localparam logic [MODE_W-1:0] M_LPM2 = 3'd3;
    localparam logic [MODE_W-1:0] M_LPM3 = 3'd4;
    localparam logic [MODE_W-1:0] M_LPM4 = 3'd5;

    typedef enum logic [1:0] {
        ST_BOOT    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_SLEEP   = 2'd2,
        ST_SERVICE = 2'd3
    } ctl_state_t;

    typedef struct packed {
        logic cpu;
        logic mclk;
        logic smclk;
        logic aclk;
        logic dcgen;
        logic xosc;
    } gate_t;

    localparam gate_t GATE_ALL_ON = '{cpu: 1'b1, mclk: 1'b1, smclk: 1'b1,
                                      aclk: 1'b1, dcgen: 1'b1, xosc: 1'b1};

    function automatic logic is_sleep_code(input logic [MODE_W-1:0] m);
        return (m >= M_LPM0) && (m <= M_LPM4);
    endfunction

endpackage

// File: rtl/lpm_vec_check.sv
module lpm_vec_check #(
    parameter int VEC_W = 16
) (
    input  logic [VEC_W-1:0] vec,
    output logic             blank
);
    localparam logic [VEC_W-1:0] BLANK_WORD = {VEC_W{1'b1}};

    always_comb begin
        blank = (vec == BLANK_WORD);
    end
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_blank,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              irq_req,
    input  logic              irq_ret,
    input  logic              save_clr,
    output logic [MODE_W-1:0] mode_q,
    output logic [MODE_W-1:0] mode_nxt,
    output logic              wake_q
);
    ctl_state_t        state_q, state_nxt;
    logic [MODE_W-1:0] saved_q, saved_nxt;
    logic              wake_nxt;
    logic [MODE_W-1:0] ret_mode;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Transition and mode-update logic
    always_comb begin
        state_nxt = state_q;
        mode_nxt  = mode_q;
        saved_nxt = saved_q;
        wake_nxt  = 1'b0;
        ret_mode  = save_clr ? M_ACT : saved_q;
        unique case (state_q)
            ST_BOOT: begin
                if (boot_blank) begin
                    state_nxt = ST_SLEEP;
                    mode_nxt  = M_LPM4;
                end else begin
                    state_nxt = ST_ACTIVE;
                    mode_nxt  = M_ACT;
                end
            end
            ST_ACTIVE: begin
                if (irq_req) begin
                    state_nxt = ST_SERVICE;
                    saved_nxt = M_ACT;
                end else if (mode_wr && is_sleep_code(mode_sel)) begin
                    state_nxt = ST_SLEEP;
                    mode_nxt  = mode_sel;
                end
            end
            ST_SLEEP: begin
                if (irq_req) begin
                    state_nxt = ST_SERVICE;
                    saved_nxt = mode_q;
                    mode_nxt  = M_ACT;
                    wake_nxt  = 1'b1;
                end
            end
            ST_SERVICE: begin
                if (irq_ret) begin
                    mode_nxt  = ret_mode;
                    saved_nxt = M_ACT;
                    state_nxt = is_sleep_code(ret_mode) ? ST_SLEEP : ST_ACTIVE;
                end else if (save_clr) begin
                    saved_nxt = M_ACT;
                end
            end
            default: begin
                state_nxt = ST_ACTIVE;
                mode_nxt  = M_ACT;
            end
        endcase
    end

    // Output registers: mode, saved mode, wake pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= M_ACT;
            saved_q <= M_ACT;
            wake_q  <= 1'b0;
        end else begin
            mode_q  <= mode_nxt;
            saved_q <= saved_nxt;
            wake_q  <= wake_nxt;
        end
    end
endmodule

// File: rtl/lpm_gate_table.sv
module lpm_gate_table
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_nxt,
    input  logic              osc_used,
    output gate_t             gate_q
);
    gate_t gate_nxt;

    always_comb begin
        gate_nxt = GATE_ALL_ON;
        unique case (mode_nxt)
            M_LPM0: begin
                gate_nxt.cpu  = 1'b0;
                gate_nxt.mclk = 1'b0;
            end
            M_LPM1: begin
                gate_nxt.cpu   = 1'b0;
                gate_nxt.mclk  = 1'b0;
                gate_nxt.dcgen = osc_used;
            end
            M_LPM2: begin
                gate_nxt.cpu   = 1'b0;
                gate_nxt.mclk  = 1'b0;
                gate_nxt.smclk = 1'b0;
            end
            M_LPM3: begin
                gate_nxt.cpu   = 1'b0;
                gate_nxt.mclk  = 1'b0;
                gate_nxt.smclk = 1'b0;
                gate_nxt.dcgen = 1'b0;
            end
            M_LPM4: begin
                gate_nxt = '0;
            end
            default: begin
                gate_nxt = GATE_ALL_ON;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= GATE_ALL_ON;
        end else begin
            gate_q <= gate_nxt;
        end
    end
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
    import lpm_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VEC_W-1:0]  rst_vec,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              irq_req,
    input  logic              irq_ret,
    input  logic              save_clr,
    input  logic              osc_used,
    output logic              cpu_en,
    output logic              mclk_en,
    output logic              smclk_en,
    output logic              aclk_en,
    output logic              dcgen_en,
    output logic              xosc_en,
    output logic [MODE_W-1:0] cur_mode,
    output logic              wake
);
    logic              boot_blank;
    logic [MODE_W-1:0] mode_q;
    logic [MODE_W-1:0] mode_nxt;
    gate_t             gate_q;

    lpm_vec_check #(.VEC_W(VEC_W)) u_vec (
        .vec   (rst_vec),
        .blank (boot_blank)
    );

    lpm_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_blank (boot_blank),
        .mode_wr    (mode_wr),
        .mode_sel   (mode_sel),
        .irq_req    (irq_req),
        .irq_ret    (irq_ret),
        .save_clr   (save_clr),
        .mode_q     (mode_q),
        .mode_nxt   (mode_nxt),
        .wake_q     (wake)
    );

    lpm_gate_table u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_nxt (mode_nxt),
        .osc_used (osc_used),
        .gate_q   (gate_q)
    );

    always_comb begin
        cur_mode = mode_q;
        cpu_en   = gate_q.cpu;
        mclk_en  = gate_q.mclk;
        smclk_en = gate_q.smclk;
        aclk_en  = gate_q.aclk;
        dcgen_en = gate_q.dcgen;
        xosc_en  = gate_q.xosc;
    end
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_req,
    input logic       osc_used,
    input logic       cpu_en,
    input logic       mclk_en,
    input logic       smclk_en,
    input logic       aclk_en,
    input logic       dcgen_en,
    input logic       xosc_en,
    input logic [2:0] cur_mode,
    input logic       wake
);
    logic [5:0] en_v;
    assign en_v = {cpu_en, mclk_en, smclk_en, aclk_en, dcgen_en, xosc_en};

    // R4: active code runs everything
    p_active_all_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd0) |-> (en_v == 6'b111111));

    // R5: dc generator in code 2 follows the previous osc_used
    p_lpm1_dcgen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd2 && $past(cur_mode) == 3'd2) |-> (dcgen_en == $past(osc_used)));

    // R7: deepest level stops everything
    p_deepest_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd5) |-> (en_v == 6'b000000));

    // R8: interrupt in sleep wakes at next edge with one-cycle wake
    p_irq_wakes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != 3'd0 && irq_req) |=> (cur_mode == 3'd0 && wake));

    p_wake_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    // R11: a sleep level holds without interrupt
    p_sleep_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != 3'd0 && !irq_req) |=> $stable(cur_mode));
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .osc_used (osc_used),
    .cpu_en   (cpu_en),
    .mclk_en  (mclk_en),
    .smclk_en (smclk_en),
    .aclk_en  (aclk_en),
    .dcgen_en (dcgen_en),
    .xosc_en  (xosc_en),
    .cur_mode (cur_mode),
    .wake     (wake)
);

// File: tb/lpm_clk_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpm_clk_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rst_vec = 16'hFFFF;
    logic        mode_wr = 1'b0;
    logic [2:0]  mode_sel = 3'd0;
    logic        irq_req = 1'b0;
    logic        irq_ret = 1'b0;
    logic        save_clr = 1'b0;
    logic        osc_used = 1'b0;
    logic        cpu_en, mclk_en, smclk_en, aclk_en, dcgen_en, xosc_en, wake;
    logic [2:0]  cur_mode;

    int    n_chk = 0;
    int    n_bad = 0;
    string tag = "R1";
    int    cycles = 0;

    always #2.5 clk = ~clk;

    lpm_clk_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .rst_vec(rst_vec), .mode_wr(mode_wr),
        .mode_sel(mode_sel), .irq_req(irq_req), .irq_ret(irq_ret),
        .save_clr(save_clr), .osc_used(osc_used), .cpu_en(cpu_en),
        .mclk_en(mclk_en), .smclk_en(smclk_en), .aclk_en(aclk_en),
        .dcgen_en(dcgen_en), .xosc_en(xosc_en), .cur_mode(cur_mode),
        .wake(wake)
    );

    // Reference model: phase 0 boot, 1 active, 2 asleep, 3 handler
    int       m_phase, m_mode, m_saved;
    bit       m_wake;
    bit [5:0] m_en;

    function automatic bit [5:0] expect_en(int md, bit osc);
        case (md)
            1: return 6'b001111;
            2: return {4'b0011, osc, 1'b1};
            3: return 6'b000111;
            4: return 6'b000101;
            5: return 6'b000000;
            default: return 6'b111111;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_mode = 0; m_saved = 0; m_wake = 0; m_en = 6'b111111;
        end else begin
            m_wake = 0;
            if (m_phase == 0) begin
                if (rst_vec == 16'hFFFF) begin m_phase = 2; m_mode = 5; end
                else m_phase = 1;
            end else if (m_phase == 1) begin
                if (irq_req) begin m_phase = 3; m_saved = 0; end
                else if (mode_wr && mode_sel >= 1 && mode_sel <= 5) begin
                    m_phase = 2; m_mode = mode_sel;
                end
            end else if (m_phase == 2) begin
                if (irq_req) begin
                    m_phase = 3; m_saved = m_mode; m_mode = 0; m_wake = 1;
                end
            end else begin
                if (irq_ret) begin
                    m_mode = save_clr ? 0 : m_saved;
                    m_saved = 0;
                    m_phase = (m_mode == 0) ? 1 : 2;
                end else if (save_clr) m_saved = 0;
            end
            m_en = expect_en(m_mode, osc_used);
        end
    end

    task automatic check(string req, logic [9:0] act, logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual mode/en/wake=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n)
            check(tag, {cur_mode, cpu_en, mclk_en, smclk_en, aclk_en, dcgen_en, xosc_en, wake},
                  {m_mode[2:0], m_en, m_wake});
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_mode(logic [2:0] code);
        mode_wr = 1'b1; mode_sel = code; step(1); mode_wr = 1'b0; step(1);
    endtask

    task automatic pulse_irq();
        irq_req = 1'b1; step(1); irq_req = 1'b0; step(1);
    endtask

    task automatic pulse_ret();
        irq_ret = 1'b1; step(1); irq_ret = 1'b0; step(1);
    endtask

    task automatic do_reset(logic [15:0] v);
        rst_n = 1'b0; rst_vec = v; step(2);
        // R1: reset state seen at the ports
        check("R1", {cur_mode, cpu_en, mclk_en, smclk_en, aclk_en, dcgen_en, xosc_en, wake},
              10'b000_111111_0);
        rst_n = 1'b1; step(2);
    endtask

    initial begin
        @(negedge clk);
        tag = "R2"; do_reset(16'hFFFF);
        rst_vec = 16'h0000; step(2);                 // R2: later vector value ignored
        tag = "R7"; step(3);
        tag = "R8"; pulse_irq(); step(2);
        tag = "R9"; pulse_ret(); step(2);             // back to code 5
        tag = "R2"; do_reset(16'h1234); step(2);
        tag = "R3"; write_mode(3'd0); write_mode(3'd6); write_mode(3'd7);
        tag = "R4"; write_mode(3'd1); step(2);
        tag = "R11"; write_mode(3'd3); irq_ret = 1'b1; save_clr = 1'b1; step(1);
        irq_ret = 1'b0; save_clr = 1'b0; step(1);
        tag = "R8"; pulse_irq();
        tag = "R11"; irq_req = 1'b1; mode_wr = 1'b1; mode_sel = 3'd5; step(1);
        irq_req = 1'b0; mode_wr = 1'b0; step(1);
        tag = "R9"; pulse_ret(); step(1);             // back to code 1
        tag = "R10"; pulse_irq(); save_clr = 1'b1; step(1); save_clr = 1'b0; step(1);
        pulse_ret(); step(1);
        tag = "R5"; osc_used = 1'b0; write_mode(3'd2); step(2);
        osc_used = 1'b1; step(3); osc_used = 1'b0; step(2);
        tag = "R10"; pulse_irq(); irq_ret = 1'b1; save_clr = 1'b1; step(1);
        irq_ret = 1'b0; save_clr = 1'b0; step(2);
        tag = "R6"; write_mode(3'd3); step(2);
        tag = "R9"; pulse_irq(); pulse_ret(); step(2);
        tag = "R10"; pulse_irq(); save_clr = 1'b1; step(1); save_clr = 1'b0; pulse_ret();
        tag = "R6"; osc_used = 1'b1; write_mode(3'd4); step(2); osc_used = 1'b0;
        tag = "R8"; pulse_irq(); save_clr = 1'b1; step(1); save_clr = 1'b0; pulse_ret();
        tag = "R7"; write_mode(3'd5); step(3);
        tag = "R9"; pulse_irq(); pulse_ret(); step(2);
        tag = "R10"; pulse_irq(); save_clr = 1'b1; step(1); save_clr = 1'b0; pulse_ret();
        tag = "R12"; irq_req = 1'b1; mode_wr = 1'b1; mode_sel = 3'd4; step(1);
        irq_req = 1'b0; mode_wr = 1'b0; step(2);
        pulse_ret(); step(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual cycles=%0d expected below 20000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule